// File: doc/BRIEF.md
# Synchronous SRAM Read Output Stage

This block is the read-data output path of a synchronous burst SRAM model. Each cycle it is given the access command that the front end has already captured: either a read, with the array's read word presented in the same cycle, or a deselect. From these it drives a data word and a tri-state enable for the shared data bus.

Two static mode inputs shape the timing. The first selects between flow-through reads, where the array word goes straight to the bus, and pipelined reads, where a rising-edge output register adds one cycle. The second selects between single-cycle deselect, where turn-off follows the deselect with the same latency as read data, and dual-cycle deselect, where the bus stays driven with the last read word for one further cycle. An output-enable input gates the drivers combinationally and does not wait for a clock edge. Counted from the address clock, the first beat takes 3 cycles in pipelined mode and 2 in flow-through mode, and each further burst beat takes 1 cycle.

Top module: `rso_read_out`

## Requirements
- R1: With `cfg_pipe`=0 (flow-through), in a cycle where `acc_read`=1 and `oe`=1, `dq_en` is 1 and `dq_out` equals `arr_data` of that same cycle.
- R2: With `cfg_pipe`=1 (pipelined), in the cycle after a cycle with `acc_read`=1, `dq_en` is 1 when `oe`=1 and `dq_out` equals the `arr_data` of that earlier read cycle.
- R3: With `cfg_dual`=0 (single-cycle deselect), a deselect (`acc_read`=0) turns the bus off with the read-data latency: in the same cycle in flow-through mode and in the next cycle in pipelined mode.
- R4: With `cfg_dual`=1 (dual-cycle deselect), after a read the first deselect keeps `dq_en` at 1 for one more cycle, showing the word of the most recent read. The bus turns off one cycle later than under R3.
- R5: `oe`=0 forces `dq_en` to 0 within the same cycle, with no clock edge needed. Raising `oe` again restores the drive in the same cycle.
- R6: A run of consecutive reads keeps `dq_en` at 1 in every cycle of the run's data window, with no gap. Each cycle shows the next word in order.
- R7: While `rst`=1, `dq_en` is 0. Reset clears the read history and the held word to 0, so in pipelined mode the first cycle after reset is undriven and `dq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pipe | input | 1 | 1 = pipelined reads, 0 = flow-through reads |
| cfg_dual | input | 1 | 1 = dual-cycle deselect, 0 = single-cycle deselect |
| oe | input | 1 | Output enable, acts without a clock edge |
| acc_read | input | 1 | Captured command this cycle: 1 = read, 0 = deselect |
| arr_data | input | DATA_W | Array read word for a read in this cycle |
| dq_out | output | DATA_W | Word presented to the bus drivers |
| dq_en | output | 1 | Bus driver enable |

## Verification
In flow-through mode, read data and single-cycle turn-off are due in the cycle of the command itself. In pipelined mode they are due one cycle later. Dual-cycle deselect moves turn-off one cycle further. Output enable acts within the cycle. The bench drives every command just after a falling edge and compares one time unit later, before the next rising edge. This catches both combinational and registered results. A queue of past commands in the bench gives the cycle each result is due. Output enable is also toggled inside a cycle, with no clock edge, and the enable is checked between the toggles.

// File: rtl/rso_pkg.sv
package rso_pkg;

    // Read latency in cycles after the access cycle, one value per read mode.
    typedef enum logic [0:0] {
        LAT_FLOW = 1'b0,
        LAT_PIPE = 1'b1
    } rso_lat_e;

    typedef struct packed {
        rso_lat_e lat;
        logic     dual;
    } rso_mode_t;

    // Largest read latency plus the extra deselect stage plus the current cycle.
    localparam int unsigned RSO_MAX_LAT = 1;
    localparam int unsigned RSO_HIST_D  = RSO_MAX_LAT + 2;

    function automatic rso_mode_t rso_mk_mode(input logic pipe, input logic dual);
        rso_mode_t m;
        m.lat  = pipe ? LAT_PIPE : LAT_FLOW;
        m.dual = dual;
        return m;
    endfunction

    // Drive request from the read history: the read whose data is due now,
    // or, in dual-cycle mode, the read one cycle older than that.
    function automatic logic rso_want_drive(input rso_mode_t m,
                                            input logic [RSO_HIST_D-1:0] h);
        logic due_now;
        logic due_prev;
        if (m.lat == LAT_PIPE) begin
            due_now  = h[1];
            due_prev = h[2];
        end else begin
            due_now  = h[0];
            due_prev = h[1];
        end
        return due_now | (m.dual & due_prev);
    endfunction

endpackage

// File: rtl/rso_cmd_hist.sv
module rso_cmd_hist #(
    parameter int unsigned DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_in,
    output logic [DEPTH-1:0] hist
);
    assign hist[0] = rd_in;

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        logic stage_q;
        always_ff @(posedge clk) begin
            if (rst) stage_q <= 1'b0;
            else     stage_q <= hist[i-1];
        end
        assign hist[i] = stage_q;
    end
endmodule

// File: rtl/rso_out_reg.sv
module rso_out_reg #(
    parameter int unsigned DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic              bypass,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst)      held_q <= '0;
        else if (cap) held_q <= d;
    end

    // Bypass lets a flow-through read reach the bus in its own cycle.
    assign q = bypass ? d : held_q;
endmodule

// File: rtl/rso_drive_ctl.sv
module rso_drive_ctl
    import rso_pkg::*;
(
    input  logic                  rst,
    input  logic                  oe,
    input  rso_mode_t             mode,
    input  logic [RSO_HIST_D-1:0] hist,
    output logic                  en
);
    logic want;

    always_comb begin
        want = rso_want_drive(mode, hist);
        en   = oe & ~rst & want;
    end
endmodule

// File: rtl/rso_read_out.sv
module rso_read_out
    import rso_pkg::*;
#(
    parameter int unsigned DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_pipe,
    input  logic              cfg_dual,
    input  logic              oe,
    input  logic              acc_read,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_en
);
    localparam int unsigned HD = RSO_HIST_D;

    rso_mode_t   mode;
    logic [HD-1:0] hist;
    logic        bypass;

    assign mode   = rso_mk_mode(cfg_pipe, cfg_dual);
    assign bypass = (mode.lat == LAT_FLOW) & acc_read;

    rso_cmd_hist #(.DEPTH(HD)) u_hist (
        .clk   (clk),
        .rst   (rst),
        .rd_in (acc_read),
        .hist  (hist)
    );

    rso_out_reg #(.DATA_W(DATA_W)) u_oreg (
        .clk    (clk),
        .rst    (rst),
        .cap    (acc_read),
        .bypass (bypass),
        .d      (arr_data),
        .q      (dq_out)
    );

    rso_drive_ctl u_ctl (
        .rst  (rst),
        .oe   (oe),
        .mode (mode),
        .hist (hist),
        .en   (dq_en)
    );
endmodule

// File: rtl/rso_read_out_chk.sv
module rso_read_out_chk #(
    parameter int unsigned DATA_W = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_pipe,
    input logic              cfg_dual,
    input logic              oe,
    input logic              acc_read,
    input logic [DATA_W-1:0] arr_data,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_en
);
    p_flow_same_cycle_r1: assert property (@(posedge clk) disable iff (rst)
        (!cfg_pipe && acc_read && oe) |-> (dq_en && dq_out == arr_data));

    p_pipe_next_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_pipe && oe && !$past(rst) && $past(acc_read))
            |-> (dq_en && dq_out == $past(arr_data)));

    p_single_off_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_pipe && !cfg_dual && !$past(rst) && !$past(acc_read)) |-> !dq_en);

    p_dual_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_pipe && cfg_dual && oe && !$past(rst) && !$past(rst, 2)
         && !$past(acc_read) && $past(acc_read, 2))
            |-> (dq_en && $stable(dq_out)));

    p_oe_gate_r5: assert property (@(posedge clk) disable iff (rst)
        !oe |-> !dq_en);

    p_no_bubble_r6: assert property (@(posedge clk) disable iff (rst)
        (oe && acc_read && !$past(rst) && $past(acc_read)) |-> dq_en);

    always @(posedge clk) begin
        if (rst) begin
            p_reset_quiet_r7: assert (!dq_en);
        end
    end
endmodule

bind rso_read_out rso_read_out_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_pipe (cfg_pipe),
    .cfg_dual (cfg_dual),
    .oe       (oe),
    .acc_read (acc_read),
    .arr_data (arr_data),
    .dq_out   (dq_out),
    .dq_en    (dq_en)
);

// File: tb/rso_read_out_bench.sv
module rso_read_out_bench;
    localparam int W = 36;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_pipe = 1'b1;
    logic         cfg_dual = 1'b0;
    logic         oe = 1'b1;
    logic         acc_read = 1'b0;
    logic [W-1:0] arr_data = '0;
    logic [W-1:0] dq_out;
    logic         dq_en;

    int checks = 0;
    int errors = 0;

    // Model state: queue of past read flags (front = previous cycle), last read word.
    logic         past_rd[$];
    logic [W-1:0] last_word;

    always #5 clk = ~clk;

    rso_read_out #(.DATA_W(W)) u_rso_read_out (
        .clk(clk), .rst(rst), .cfg_pipe(cfg_pipe), .cfg_dual(cfg_dual),
        .oe(oe), .acc_read(acc_read), .arr_data(arr_data),
        .dq_out(dq_out), .dq_en(dq_en)
    );

    function automatic logic ago(input int n);
        if (n == 0) return acc_read;
        if (past_rd.size() >= n) return past_rd[n-1];
        return 1'b0;
    endfunction

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s dq_en actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_word(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s dq_out actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_now(input string tag);
        int lat;
        logic want;
        logic [W-1:0] word;
        lat  = cfg_pipe ? 1 : 0;
        want = ago(lat) || (cfg_dual && ago(lat + 1));
        word = (!cfg_pipe && acc_read) ? arr_data : last_word;
        chk_bit(tag, dq_en, oe && !rst && want);
        if (oe && !rst && want) chk_word(tag, dq_out, word);
    endtask

    task automatic step(input logic r, input logic [W-1:0] d, input string tag);
        @(negedge clk);
        acc_read = r;
        arr_data = d;
        #1;
        compare_now(tag);
        @(posedge clk);
        past_rd.push_front(r);
        if (past_rd.size() > 4) void'(past_rd.pop_back());
        if (r) last_word = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        acc_read = 1'b1;
        arr_data = 36'hBAD_BAD_BA;
        #1;
        chk_bit("R7", dq_en, 1'b0);
        @(posedge clk);
        @(negedge clk);
        acc_read = 1'b0;
        rst = 1'b0;
        past_rd.delete();
        last_word = '0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        last_word = '0;
        repeat (3) @(posedge clk);
        do_reset();
        // R7: first cycle after reset, pipelined, undriven, held word zero
        #1;
        chk_bit("R7", dq_en, 1'b0);
        chk_word("R7", dq_out, '0);

        // Pipelined, single-cycle deselect: burst of four then deselect
        cfg_pipe = 1'b1; cfg_dual = 1'b0;
        for (int i = 0; i < 4; i++) step(1'b1, 36'h100 + W'(i), "R2");
        step(1'b0, '0, "R6");
        step(1'b0, '0, "R3");
        step(1'b1, 36'hA5A5_0001, "R3");
        step(1'b0, '0, "R2");
        step(1'b0, '0, "R3");

        // Pipelined, dual-cycle deselect
        cfg_dual = 1'b1;
        step(1'b0, '0, "R4");
        step(1'b1, 36'h5_1234_5678, "R4");
        step(1'b1, 36'h6_8765_4321, "R6");
        step(1'b0, 36'hF_FFFF_FFFF, "R4");
        step(1'b0, '0, "R4");
        step(1'b0, '0, "R4");

        // Flow-through, single-cycle deselect
        cfg_pipe = 1'b0; cfg_dual = 1'b0;
        step(1'b0, '0, "R3");
        for (int i = 0; i < 3; i++) step(1'b1, 36'h7_0000_0000 + W'(i * 3), "R1");
        step(1'b0, '0, "R3");
        step(1'b1, 36'h0_0000_0001, "R1");
        step(1'b0, '0, "R3");

        // Flow-through, dual-cycle deselect
        cfg_dual = 1'b1;
        step(1'b1, 36'hC_0FFE_E000, "R1");
        step(1'b0, 36'h1_1111_1111, "R4");
        step(1'b0, '0, "R4");

        // R5: output enable toggled inside a cycle, no clock edge between
        cfg_pipe = 1'b1; cfg_dual = 1'b0;
        step(1'b1, 36'h9_9999_0000, "R5");
        @(negedge clk);
        acc_read = 1'b1; arr_data = 36'h9_9999_0001;
        #1; chk_bit("R5", dq_en, 1'b1);
        oe = 1'b0;
        #1; chk_bit("R5", dq_en, 1'b0);
        oe = 1'b1;
        #1; chk_bit("R5", dq_en, 1'b1);
        chk_word("R5", dq_out, 36'h9_9999_0000);
        @(posedge clk);
        past_rd.push_front(1'b1);
        last_word = 36'h9_9999_0001;
        oe = 1'b0;
        step(1'b1, 36'h2, "R5");
        step(1'b0, '0, "R5");
        oe = 1'b1;
        step(1'b0, '0, "R3");

        // Alternating reads and deselects in each mode
        for (int m = 0; m < 4; m++) begin
            cfg_pipe = m[0]; cfg_dual = m[1];
            step(1'b0, '0, "R3");
            step(1'b0, '0, "R3");
            for (int k = 0; k < 6; k++)
                step(k[0] == 1'b0, 36'h3_0000_0000 + W'(m * 16 + k), cfg_dual ? "R4" : "R3");
        end

        // Reset in the middle of traffic
        cfg_pipe = 1'b1; cfg_dual = 1'b1;
        step(1'b1, 36'hE_EEEE_EEEE, "R7");
        do_reset();
        #1;
        chk_bit("R7", dq_en, 1'b0);
        chk_word("R7", dq_out, '0);
        step(1'b0, '0, "R7");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule